// File: doc/BRIEF.md
# Subtract-and-Branch-If-Not-Positive Processor Core

This block is a small multi-cycle processor that runs a single instruction: subtract one memory word from another, store the difference, and branch when the difference is not positive. There are no opcodes. The program counter is the only register the program can see, and all data lives in an internal word-addressed RAM. The program counter counts whole instructions. Each instruction is three consecutive words: A, B and C. A and B are data addresses. C is the instruction index to branch to.

A program and its data are written into the RAM through a load port while the core is held in reset. After reset is released the core steps through the program one instruction at a time. A one-cycle pulse marks each completed step, so an outside observer can compare the program counter and memory with a reference model after every instruction. A combinational debug port reads any RAM word. The core stops for good (halts) on a terminal branch target, on a target that falls outside the RAM, or on a data address that falls outside the RAM.

Top module: `subleq_core`

## Requirements
- R1: The instruction at program counter value P occupies words 3P, 3P+1 and 3P+2, holding the A address, the B address and the branch index C in that order. After reset, P is 0.
- R2: Each step writes the 16-bit wrapping difference Mem[B] - Mem[A] into Mem[B]. The new value can be read on the debug port once the step pulse appears.
- R3: If the written difference is zero or has bit 15 set (negative in two's complement), the program counter becomes C.
- R4: If the written difference is positive (bit 15 clear and not zero), the program counter becomes P+1.
- R5: When A equals B, the written value is 0 and the program counter becomes C.
- R6: A step takes exactly seven clock cycles. `stepDone` is high for one cycle, on the cycle after the 7th rising edge of the step, and the program counter changes only on that edge.
- R7: The core halts after its write if the next index would be C = 16'hFFFF, or if the next index N (C or P+1) has 3N+2 above the last RAM address (N > 84 for 256 words). On a halt, `halted` rises on the 7th edge and stays high, `stepDone` stays low, and the program counter keeps P.
- R8: If A or B is 256 or more, the core halts on the 4th edge of that step. It makes no write and leaves the program counter unchanged.
- R9: While halted, the core writes no RAM word.
- R10: With `rstN` low, a high `loadEn` writes `loadData` into word `loadAddr` on the rising edge. With `rstN` high, `loadEn` has no effect on the RAM.
- R11: While `rstN` is low, `pc` is 0 and `halted` and `stepDone` are low.
- R12: `dbgData` always shows the current content of word `dbgAddr`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset. The RAM can be loaded while this is low |
| loadEn | input | 1 | Load write strobe, used only while in reset |
| loadAddr | input | ADDR_W | Word address for loading |
| loadData | input | DATA_W | Word to load |
| dbgAddr | input | ADDR_W | Debug read address |
| dbgData | output | DATA_W | Content of word `dbgAddr`, read combinationally |
| pc | output | ADDR_W | Program counter, as an instruction index |
| halted | output | 1 | Halt flag. Once set, it stays set until reset |
| stepDone | output | 1 | One-cycle pulse after each program counter update |

## Verification
The bench counts clock cycles from the falling edge at which reset is released or the previous step pulse was seen. The program counter, `stepDone` and the stored difference are all checked at the seventh falling edge. `stepDone` must be low at the six falling edges before that. An out-of-range data address is checked at the fourth falling edge instead, and a halting branch at the seventh. The debug port is combinational, so the written word is read a fraction of a nanosecond after the falling edge, well before the next rising edge. The whole RAM is compared with the model only once the core has halted, because then nothing can change it.

// File: rtl/subleq_pkg.sv
`timescale 1ns/1ps
package subleq_pkg;

  // One state per RAM access, plus the terminal state
  typedef enum logic [2:0] {
    ST_FETCH_A,
    ST_FETCH_B,
    ST_FETCH_C,
    ST_READ_A,
    ST_READ_B,
    ST_WRITE_B,
    ST_NEXT_PC,
    ST_HALT
  } stateT;

  // Source of the single RAM port address
  typedef enum logic [2:0] {
    SEL_WORD0,
    SEL_WORD1,
    SEL_WORD2,
    SEL_OPA,
    SEL_OPB
  } addrSelT;

  // Strobes from control to datapath
  typedef struct packed {
    addrSelT addrSel;
    logic    capOpA;
    logic    capOpB;
    logic    capOpC;
    logic    capValA;
    logic    writeB;
    logic    advancePc;
  } strobeT;

endpackage

// File: rtl/subleq_ram.sv
`timescale 1ns/1ps
module subleq_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [DATA_W-1:0] dbgData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Single synchronous port: read data arrives one edge after the address
  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
    rdata <= store[addr];
  end

  assign dbgData = store[dbgAddr];
endmodule

// File: rtl/subleq_ctrl.sv
`timescale 1ns/1ps
module subleq_ctrl
  import subleq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   operandsOk,
  input  logic   nextOk,
  output strobeT strobe,
  output logic   halted,
  output logic   stepDone
);
  stateT state, stateNext;

  always_comb begin
    stateNext        = state;
    strobe.addrSel   = SEL_WORD0;
    strobe.capOpA    = 1'b0;
    strobe.capOpB    = 1'b0;
    strobe.capOpC    = 1'b0;
    strobe.capValA   = 1'b0;
    strobe.writeB    = 1'b0;
    strobe.advancePc = 1'b0;
    unique case (state)
      ST_FETCH_A: begin
        strobe.addrSel = SEL_WORD0;
        stateNext      = ST_FETCH_B;
      end
      ST_FETCH_B: begin
        strobe.addrSel = SEL_WORD1;
        strobe.capOpA  = 1'b1;
        stateNext      = ST_FETCH_C;
      end
      ST_FETCH_C: begin
        strobe.addrSel = SEL_WORD2;
        strobe.capOpB  = 1'b1;
        stateNext      = ST_READ_A;
      end
      ST_READ_A: begin
        strobe.capOpC = 1'b1;
        if (operandsOk) begin
          strobe.addrSel = SEL_OPA;
          stateNext      = ST_READ_B;
        end else begin
          stateNext = ST_HALT;
        end
      end
      ST_READ_B: begin
        strobe.addrSel = SEL_OPB;
        strobe.capValA = 1'b1;
        stateNext      = ST_WRITE_B;
      end
      ST_WRITE_B: begin
        strobe.addrSel = SEL_OPB;
        strobe.writeB  = 1'b1;
        stateNext      = ST_NEXT_PC;
      end
      ST_NEXT_PC: begin
        if (nextOk) begin
          strobe.advancePc = 1'b1;
          stateNext        = ST_FETCH_A;
        end else begin
          stateNext = ST_HALT;
        end
      end
      ST_HALT: stateNext = ST_HALT;
      default: stateNext = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_FETCH_A;
      stepDone <= 1'b0;
    end else begin
      state    <= stateNext;
      stepDone <= strobe.advancePc;
    end
  end

  assign halted = (state == ST_HALT);
endmodule

// File: rtl/subleq_datapath.sv
`timescale 1ns/1ps
module subleq_datapath
  import subleq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWe,
  output logic [DATA_W-1:0] ramWdata,
  output logic [ADDR_W-1:0] pc,
  output logic              operandsOk,
  output logic              nextOk
);
  localparam int MEM_WORDS = 1 << ADDR_W;
  localparam int LAST_IDX  = (MEM_WORDS - 3) / 3;
  localparam int IDX_W     = DATA_W + 1;

  logic [DATA_W-1:0] opA, opB, opC, valA, diff;
  logic              resultLe;
  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  nextIdx;

  // Instruction base word is three times the instruction index
  assign base = pc + pc + pc;

  always_comb begin
    unique case (strobe.addrSel)
      SEL_WORD0: ramAddr = base;
      SEL_WORD1: ramAddr = base + ADDR_W'(1);
      SEL_WORD2: ramAddr = base + ADDR_W'(2);
      SEL_OPA:   ramAddr = opA[ADDR_W-1:0];
      SEL_OPB:   ramAddr = opB[ADDR_W-1:0];
      default:   ramAddr = base;
    endcase
  end

  assign diff     = rdData - valA;
  assign ramWdata = diff;
  assign ramWe    = strobe.writeB;

  assign operandsOk = ((opA >> ADDR_W) == '0) && ((opB >> ADDR_W) == '0);

  assign nextIdx = resultLe ? {1'b0, opC} : (IDX_W'(pc) + IDX_W'(1));
  assign nextOk  = !(resultLe && (&opC)) && (nextIdx <= IDX_W'(LAST_IDX));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opA      <= '0;
      opB      <= '0;
      opC      <= '0;
      valA     <= '0;
      resultLe <= 1'b0;
      pc       <= '0;
    end else begin
      if (strobe.capOpA)  opA  <= rdData;
      if (strobe.capOpB)  opB  <= rdData;
      if (strobe.capOpC)  opC  <= rdData;
      if (strobe.capValA) valA <= rdData;
      if (strobe.writeB)  resultLe <= diff[DATA_W-1] || (diff == '0);
      if (strobe.advancePc) pc <= nextIdx[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/subleq_core.sv
`timescale 1ns/1ps
module subleq_core
  import subleq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic [ADDR_W-1:0] dbgAddr,
  output logic [DATA_W-1:0] dbgData,
  output logic [ADDR_W-1:0] pc,
  output logic              halted,
  output logic              stepDone
);
  strobeT            strobe;
  logic              operandsOk, nextOk;
  logic [ADDR_W-1:0] coreAddr, ramAddr;
  logic [DATA_W-1:0] coreWdata, ramWdata, rdData;
  logic              coreWe, ramWe;

  // The load port owns the RAM while the core is in reset
  assign ramAddr  = rstN ? coreAddr : loadAddr;
  assign ramWdata = rstN ? coreWdata : loadData;
  assign ramWe    = rstN ? (coreWe && !halted) : loadEn;

  subleq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .operandsOk(operandsOk),
    .nextOk    (nextOk),
    .strobe    (strobe),
    .halted    (halted),
    .stepDone  (stepDone)
  );

  subleq_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdData    (rdData),
    .ramAddr   (coreAddr),
    .ramWe     (coreWe),
    .ramWdata  (coreWdata),
    .pc        (pc),
    .operandsOk(operandsOk),
    .nextOk    (nextOk)
  );

  subleq_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk    (clk),
    .we     (ramWe),
    .addr   (ramAddr),
    .wdata  (ramWdata),
    .rdata  (rdData),
    .dbgAddr(dbgAddr),
    .dbgData(dbgData)
  );
endmodule

// File: rtl/subleq_core_chk.sv
`timescale 1ns/1ps
module subleq_core_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] pc,
  input logic              halted,
  input logic              stepDone,
  input logic              ramWe
);
  localparam int LAST_IDX = ((1 << ADDR_W) - 3) / 3;

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN) halted |=> halted); // R7
  AST_NO_STEP_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rstN) halted |-> !stepDone); // R7
  AST_NO_WRITE_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rstN) halted |-> !ramWe); // R9
  AST_STEP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) stepDone |=> !stepDone); // R6
  AST_PC_MOVES_ON_STEP: assert property (@(posedge clk) disable iff (!rstN) !$stable(pc) |-> stepDone); // R6
  AST_PC_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN) 32'(pc) <= LAST_IDX); // R1
endmodule

bind subleq_core subleq_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pc      (pc),
  .halted  (halted),
  .stepDone(stepDone),
  .ramWe   (ramWe)
);

// File: tb/subleq_core_test.sv
`timescale 1ns/1ps
module subleq_core_test;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 8;
  localparam int MEM_WORDS = 1 << ADDR_W;
  localparam int LAST_IDX  = (MEM_WORDS - 3) / 3;
  localparam int WATCHDOG  = 190000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              loadEn = 1'b0;
  logic [ADDR_W-1:0] loadAddr = '0;
  logic [DATA_W-1:0] loadData = '0;
  logic [ADDR_W-1:0] dbgAddr = '0;
  logic [DATA_W-1:0] dbgData;
  logic [ADDR_W-1:0] pc;
  logic              halted, stepDone;

  subleq_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .dbgAddr(dbgAddr), .dbgData(dbgData),
    .pc(pc), .halted(halted), .stepDone(stepDone)
  );

  always #2 clk = ~clk;  // 250 MHz

  int total = 0, bad = 0, cycles = 0;
  logic [DATA_W-1:0] model [MEM_WORDS];
  int pcM;

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG) begin
      total++; bad++;
      $display("FAIL watchdog: act=%0d cycles exp=<%0d", cycles, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic peek(input int addr, output int val);
    dbgAddr = addr[ADDR_W-1:0];
    #0.1;
    val = int'(dbgData);
  endtask

  // R12 / R9: every RAM word equals the model
  task automatic compareAll(input string req);
    int v, mism, firstA;
    mism = 0; firstA = -1;
    for (int a = 0; a < MEM_WORDS; a++) begin
      peek(a, v);
      if (v != int'(model[a])) begin
        mism++;
        if (firstA < 0) firstA = a;
      end
    end
    if (mism != 0) $display("first mismatch at word %0d", firstA);
    check(req, mism, 0);
  endtask

  // Reference step: 0 normal, 1 operand out of range, 2 halting branch
  function automatic int stepModel(output int bA, output int le, output int same);
    int a, b, c, nxt;
    logic [DATA_W-1:0] r;
    a = int'(model[3*pcM]);
    b = int'(model[3*pcM+1]);
    c = int'(model[3*pcM+2]);
    bA = b; same = (a == b) ? 1 : 0; le = 0;
    if (a >= MEM_WORDS || b >= MEM_WORDS) return 1;
    r = model[b] - model[a];
    model[b] = r;
    le = (r[DATA_W-1] || r == '0) ? 1 : 0;
    nxt = (le != 0) ? c : pcM + 1;
    if ((le != 0 && c == 16'hFFFF) || nxt > LAST_IDX) return 2;
    pcM = nxt;
    return 0;
  endfunction

  task automatic runProgram(input int maxSteps);
    int kind, bA, le, same, v, early;
    rstN = 1'b0;
    for (int a = 0; a < MEM_WORDS; a++) begin
      @(negedge clk);
      loadEn = 1'b1; loadAddr = a[ADDR_W-1:0]; loadData = model[a];
    end
    @(negedge clk);
    loadEn = 1'b0;
    check("R11 pc in reset", int'(pc), 0);
    check("R11 halted in reset", int'(halted), 0);
    check("R11 stepDone in reset", int'(stepDone), 0);
    pcM = 0;
    rstN = 1'b1;
    for (int s = 0; s < maxSteps; s++) begin
      kind = stepModel(bA, le, same);
      if (kind == 1) begin
        repeat (4) @(negedge clk);
        check("R8 halted on bad operand", int'(halted), 1);
        check("R8 pc kept", int'(pc), pcM);
        repeat (3) @(negedge clk);
        check("R8 stepDone low", int'(stepDone), 0);
        compareAll("R8 no write on bad operand");
        return;
      end
      early = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (stepDone || halted) early++;
      end
      check("R6 nothing before 7th edge", early, 0);
      @(negedge clk);
      if (kind == 2) begin
        check("R7 halted", int'(halted), 1);
        check("R7 no stepDone", int'(stepDone), 0);
        check("R7 pc kept", int'(pc), pcM);
        peek(bA, v);
        check("R2 write before halt", v, int'(model[bA]));
        repeat (5) @(negedge clk);
        check("R7 halt sticky", int'(halted), 1);
        compareAll("R9 no writes while halted");
        // R10: load strobe with reset high is ignored
        loadEn = 1'b1; loadAddr = 8'd40; loadData = ~model[40];
        repeat (2) @(negedge clk);
        loadEn = 1'b0;
        peek(40, v);
        check("R10 load ignored out of reset", v, int'(model[40]));
        return;
      end
      check("R6 stepDone pulse", int'(stepDone), 1);
      if (same != 0) check("R5 A==B branches", int'(pc), pcM);
      else if (le != 0) check("R3 branch on <=0", int'(pc), pcM);
      else check("R4 advance on >0", int'(pc), pcM);
      peek(bA, v);
      if (same != 0) check("R5 A==B gives zero", v, 0);
      check("R2 stored difference", v, int'(model[bA]));
    end
  endtask

  function automatic void clearModel();
    for (int a = 0; a < MEM_WORDS; a++) model[a] = '0;
  endfunction

  function automatic void putInst(input int idx, input int a, input int b, input int c);
    model[3*idx]   = DATA_W'(a);
    model[3*idx+1] = DATA_W'(b);
    model[3*idx+2] = DATA_W'(c);
  endfunction

  function automatic int pickAddr();
    if ($urandom_range(0, 99) < 2) return 256 + int'($urandom_range(0, 500));
    return 120 + int'($urandom_range(0, 135));
  endfunction

  function automatic void genRandom(input int nInst);
    int a, b, c, r;
    for (int w = 0; w < MEM_WORDS; w++)
      model[w] = DATA_W'($urandom_range(0, 40)) - DATA_W'(20);
    for (int i = 0; i < nInst; i++) begin
      a = pickAddr();
      b = ($urandom_range(0, 9) == 0) ? a : pickAddr();
      r = int'($urandom_range(0, 99));
      if (r < 3) c = 16'hFFFF;
      else if (r < 6) c = LAST_IDX + 1 + int'($urandom_range(0, 20));
      else c = int'($urandom_range(0, nInst - 1));
      putInst(i, a, b, c);
    end
  endfunction

  initial begin
    void'($urandom(32'd20240611));

    // Self-looping countdown ending on the terminal branch index (R5, R7)
    clearModel();
    putInst(0, 200, 201, 2);
    putInst(1, 202, 202, 0);
    putInst(2, 202, 202, 16'hFFFF);
    model[200] = 16'd1; model[201] = 16'd3;
    runProgram(50);

    // Sequential run past the last instruction slot (R4, R7)
    clearModel();
    putInst(0, 202, 202, LAST_IDX);
    putInst(LAST_IDX, 203, 204, 0);
    model[203] = 16'hFFFB;
    runProgram(50);

    // Out-of-range data address (R8)
    clearModel();
    putInst(0, 205, 206, 1);
    putInst(1, 256, 206, 0);
    model[205] = 16'd2; model[206] = 16'd7;
    runProgram(50);

    // Branch index beyond memory (R7)
    clearModel();
    putInst(0, 202, 202, LAST_IDX + 1);
    runProgram(50);

    // Wrap to positive, then a negative result branch (R2, R3, R4)
    clearModel();
    putInst(0, 209, 210, 3);
    putInst(1, 207, 208, 3);
    putInst(3, 202, 202, 16'hFFFF);
    model[209] = 16'd1; model[210] = 16'h8000;
    model[207] = 16'd10; model[208] = 16'd3;
    runProgram(50);

    // Random programs
    for (int run = 0; run < 24; run++) begin
      genRandom(12 + int'($urandom_range(0, 16)));
      runProgram(200);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule